// File: doc/BRIEF.md
# Reciprocal and Totalizing Frequency Counter Engine

This block measures a digital pulse train against a reference clock. In frequency mode it opens a measurement window whose length is a power of ten of reference cycles, taken from a free-running chain of divide-by-ten stages, and counts the rising edges of the input that arrive while the window is open. With a window of one second of reference time the count is the input frequency in hertz. In general the count is the rate of whichever signal is counted, multiplied by the length of the window set by the other signal.

In period mode the roles swap. A rising edge of the input opens the window, and the window closes on a later rising edge, one period or several periods on. The block counts reference cycles while the window is open. Averaging over several periods returns the total over all of them, so software divides by the period count.

The reference clock is the block's clock `clk`. The input `sig_in` may be asynchronous; it passes through a synchronizer before its edges are detected. Each result leaves on a valid/ready stream. A result stays on the port until it is accepted, and the next measurement cannot begin until then. This is the only back-pressure path.

Top module: `ucnt_engine`

## Requirements
- R1: After reset, `res_valid` and `busy` are 0, and `res_valid` is never 1 while `busy` is 0.
- R2: In frequency mode (`mode`=0) the window opens on a terminal count of the selected divider stage and lasts exactly 10^`gate_exp` reference cycles. The count equals the number of input rising edges in that window, which is exact when the input period divides the window.
- R3: The counter saturates at 2^CNT_W-1 and does not wrap. When it is already saturated and a further increment arrives, `res_ovf` is 1 with the result.
- R4: In period mode (`mode`=1) the window runs from one input rising edge to the N-th following rising edge, where N is `n_avg`, and a value of 0 is treated as 1. The count is the number of reference cycles in the window, which is N times the input period.
- R5: When the input period does not divide the window, the frequency-mode count is within one count of the true ratio: floor or floor+1.
- R6: While `res_valid`=1 and `res_ready`=0, `res_valid` stays 1 and `res_count` and `res_ovf` do not change. A result is consumed on a clock edge where both are 1.
- R7: `start` is ignored while `busy`=1.
- R8: Each measurement begins from a cleared count and a cleared overflow. A result never includes counts from an earlier measurement.
- R9: `mode`, `gate_exp` and `n_avg` are captured when a measurement starts. Changes to them during the measurement have no effect on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, which also serves as the timebase |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a measurement (accepted only when idle) |
| mode | input | 1 | 0 = frequency (count input edges), 1 = period (count reference cycles) |
| gate_exp | input | GEXP_W (3) | Frequency-mode window is 10^gate_exp cycles, clamped to NUM_DEC |
| n_avg | input | AVG_W (8) | Periods per period-mode measurement; 0 treated as 1 |
| sig_in | input | 1 | Conditioned input pulse train, may be asynchronous |
| busy | output | 1 | A measurement is armed, running, or waiting to be read |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts the result |
| res_count | output | CNT_W (32) | Measured count |
| res_ovf | output | 1 | Count saturated during the measurement |

## Verification
The assertions check four rules on every cycle. A frequency window opens and closes only on a divider terminal count. A period window closes only on a detected input edge. The counter reads zero when a window opens. Results and captured settings stay still while they are held. Only the bench's scenarios can show that the numbers are right: the exact edge totals for dividing periods, the floor/ceiling spread for a non-dividing period, N times the period in averaging mode, saturation in both modes, and results that stay unaffected by a second start or by setting changes during a run.

// File: rtl/ucnt_pkg.sv
package ucnt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARM   = 3'd1,
    ST_OPEN  = 3'd2,
    ST_CLOSE = 3'd3,
    ST_HOLD  = 3'd4
  } ucnt_state_e;

  localparam logic MODE_FREQ = 1'b0;
  localparam logic MODE_PER  = 1'b1;
endpackage

// File: rtl/ucnt_edge_sync.sv
module ucnt_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic rise
);
  logic [SYNC_STAGES:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[SYNC_STAGES-1:0], sig_in};
  end

  // new high level after the synchronizer, previous sample low
  assign rise = shreg[SYNC_STAGES-1] & ~shreg[SYNC_STAGES];
endmodule

// File: rtl/ucnt_decade_chain.sv
module ucnt_decade_chain #(
  parameter int NUM_DEC = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [NUM_DEC:0] tc
);
  logic [NUM_DEC:0] carry;
  assign carry[0] = 1'b1;

  // Each stage advances when every stage below sits at nine,
  // so carry[i] pulses once every 10^i cycles.
  for (genvar i = 0; i < NUM_DEC; i++) begin : g_dec
    logic [3:0] digit;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        digit <= '0;
      else if (carry[i]) digit <= (digit == 4'd9) ? 4'd0 : digit + 4'd1;
    end
    assign carry[i+1] = carry[i] & (digit == 4'd9);
  end

  assign tc = carry;
endmodule

// File: rtl/ucnt_sat_acc.sv
module ucnt_sat_acc #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] value,
  output logic         ovf
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
      ovf   <= 1'b0;
    end else if (clr) begin
      value <= '0;
      ovf   <= 1'b0;
    end else if (inc) begin
      if (value == MAXV) ovf   <= 1'b1;
      else               value <= value + 1'b1;
    end
  end
endmodule

// File: rtl/ucnt_engine.sv
module ucnt_engine #(
  parameter int CNT_W       = 32,
  parameter int AVG_W       = 8,
  parameter int NUM_DEC     = 7,
  parameter int SYNC_STAGES = 2,
  localparam int GEXP_W     = $clog2(NUM_DEC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode,
  input  logic [GEXP_W-1:0] gate_exp,
  input  logic [AVG_W-1:0]  n_avg,
  input  logic              sig_in,
  output logic              busy,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [CNT_W-1:0]  res_count,
  output logic              res_ovf
);
  import ucnt_pkg::*;

  localparam logic [GEXP_W-1:0] GEXP_MAX = GEXP_W'(NUM_DEC);

  ucnt_state_e       state;
  logic              mode_q;
  logic [GEXP_W-1:0] gexp_q;
  logic [AVG_W-1:0]  navg_q;
  logic [AVG_W-1:0]  per_cnt;
  logic [NUM_DEC:0]  tc_vec;
  logic              tc_sel;
  logic              rise;
  logic              gate_open;
  logic              open_now;
  logic              close_now;
  logic              acc_clr;
  logic              acc_inc;
  logic [CNT_W-1:0]  acc_val;
  logic              acc_ovf;
  logic [CNT_W-1:0]  res_q;
  logic              ovf_q;

  ucnt_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .rise(rise)
  );

  ucnt_decade_chain #(.NUM_DEC(NUM_DEC)) tb_chain_i (
    .clk(clk), .rst_n(rst_n), .tc(tc_vec)
  );

  ucnt_sat_acc #(.W(CNT_W)) acc_i (
    .clk(clk), .rst_n(rst_n), .clr(acc_clr), .inc(acc_inc),
    .value(acc_val), .ovf(acc_ovf)
  );

  assign tc_sel    = tc_vec[gexp_q];
  assign gate_open = (state == ST_OPEN);

  // window edges: divider terminal count or input edge, never mid-interval
  always_comb begin
    open_now  = 1'b0;
    close_now = 1'b0;
    if (state == ST_ARM)
      open_now = (mode_q == MODE_PER) ? rise : tc_sel;
    if (state == ST_OPEN)
      close_now = (mode_q == MODE_PER) ? (rise && (per_cnt == navg_q - 1'b1)) : tc_sel;
  end

  assign acc_clr = open_now || (state == ST_CLOSE);
  assign acc_inc = gate_open && ((mode_q == MODE_PER) ? 1'b1 : rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      mode_q  <= MODE_FREQ;
      gexp_q  <= '0;
      navg_q  <= AVG_W'(1);
      per_cnt <= '0;
      res_q   <= '0;
      ovf_q   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            mode_q <= mode;
            gexp_q <= (gate_exp > GEXP_MAX) ? GEXP_MAX : gate_exp;
            navg_q <= (n_avg == '0) ? AVG_W'(1) : n_avg;
            state  <= ST_ARM;
          end
        end
        ST_ARM: begin
          if (open_now) begin
            per_cnt <= '0;
            state   <= ST_OPEN;
          end
        end
        ST_OPEN: begin
          if (rise) per_cnt <= per_cnt + 1'b1;
          if (close_now) state <= ST_CLOSE;
        end
        ST_CLOSE: begin
          res_q <= acc_val;
          ovf_q <= acc_ovf;
          state <= ST_HOLD;
        end
        ST_HOLD: begin
          if (res_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign res_valid = (state == ST_HOLD);
  assign res_count = res_q;
  assign res_ovf   = ovf_q;
endmodule

// File: rtl/ucnt_engine_chk.sv
module ucnt_engine_chk #(
  parameter int CNT_W  = 32,
  parameter int GEXP_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              res_valid,
  input logic              res_ready,
  input logic [CNT_W-1:0]  res_count,
  input logic              res_ovf,
  input logic              gate_open,
  input logic              mode_q,
  input logic [GEXP_W-1:0] gexp_q,
  input logic              tc_sel,
  input logic              rise,
  input logic [CNT_W-1:0]  acc_val,
  input logic              acc_ovf
);
  p_valid_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> busy);

  p_freq_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_open) && !mode_q) |-> $past(tc_sel));

  p_freq_close_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gate_open) && !mode_q) |-> $past(tc_sel));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ovf) |-> (res_count == {CNT_W{1'b1}}));

  p_per_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gate_open) && mode_q) |-> $past(rise));

  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_count) && $stable(res_ovf)));

  p_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_open) |-> (acc_val == '0 && !acc_ovf));

  p_settings_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(mode_q) && $stable(gexp_q)));
endmodule

bind ucnt_engine ucnt_engine_chk #(.CNT_W(CNT_W), .GEXP_W(GEXP_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .res_valid(res_valid),
  .res_ready(res_ready), .res_count(res_count), .res_ovf(res_ovf),
  .gate_open(gate_open), .mode_q(mode_q), .gexp_q(gexp_q),
  .tc_sel(tc_sel), .rise(rise), .acc_val(acc_val), .acc_ovf(acc_ovf)
);

// File: tb/ucnt_engine_tb.sv
module ucnt_engine_tb_top;
  localparam int CNT_W = 12;
  localparam int AVG_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             mode = 1'b0;
  logic [2:0]       gate_exp = '0;
  logic [AVG_W-1:0] n_avg = '0;
  logic             sig_in = 1'b0;
  logic             busy;
  logic             res_valid;
  logic             res_ready = 1'b0;
  logic [CNT_W-1:0] res_count;
  logic             res_ovf;

  int n_vec = 0;
  int n_bad = 0;
  int gen_per = 0;

  always #2 clk = ~clk;

  ucnt_engine #(.CNT_W(CNT_W), .AVG_W(AVG_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .gate_exp(gate_exp), .n_avg(n_avg), .sig_in(sig_in), .busy(busy),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_count(res_count), .res_ovf(res_ovf)
  );

  // pulse train: one rising edge every gen_per cycles, low when 0
  initial begin
    int phase = 0;
    forever begin
      @(negedge clk);
      if (gen_per < 2) begin
        sig_in = 1'b0;
        phase = 0;
      end else begin
        sig_in = (phase < gen_per / 2);
        phase = (phase + 1) % gen_per;
      end
    end
  end

  task automatic check(string req, longint act, longint exp_v);
    n_vec++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic set_input(int per);
    gen_per = per;
    repeat (3 * per + 20) @(negedge clk);
  endtask

  task automatic kick(logic m, int ge, int na);
    @(negedge clk);
    mode = m; gate_exp = 3'(ge); n_avg = AVG_W'(na); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_result(output int cnt, output int ovf);
    int t = 0;
    while (!res_valid && t < 30000) begin
      @(negedge clk);
      t++;
    end
    cnt = res_count;
    ovf = res_ovf;
    if (!res_valid) begin
      n_vec++; n_bad++;
      $display("FAIL timeout: actual res_valid 0 expected 1");
    end
  endtask

  task automatic accept();
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  task automatic measure(logic m, int ge, int na, output int cnt, output int ovf);
    kick(m, ge, na);
    wait_result(cnt, ovf);
    accept();
  endtask

  task automatic t_reset();
    check("R1 res_valid after reset", res_valid, 0);
    check("R1 busy after reset", busy, 0);
  endtask

  task automatic t_freq_exact();
    int c, o;
    set_input(0);
    measure(1'b0, 3, 0, c, o);
    check("R2 no edges k=3", c, 0);
    set_input(10);
    measure(1'b0, 3, 0, c, o);
    check("R2 period 10 k=3", c, 100);
    check("R2 no ovf", o, 0);
    set_input(2);
    measure(1'b0, 1, 0, c, o);
    check("R2 period 2 k=1", c, 5);
    set_input(4);
    measure(1'b0, 4, 0, c, o);
    check("R2 period 4 k=4", c, 2500);
    set_input(5);
    measure(1'b0, 0, 0, c, o);
    check("R2 k=0 single cycle window", (c <= 1) ? 1 : 0, 1);
  endtask

  task automatic t_freq_quant();
    int c, o;
    set_input(7);
    for (int i = 0; i < 3; i++) begin
      measure(1'b0, 2, 0, c, o);
      check("R5 period 7 k=2 within 14..15", (c == 14 || c == 15) ? 1 : 0, 1);
    end
  endtask

  task automatic t_period();
    int c, o;
    set_input(50);
    measure(1'b1, 0, 1, c, o);
    check("R4 one period of 50", c, 50);
    measure(1'b1, 0, 0, c, o);
    check("R4 n_avg 0 treated as 1", c, 50);
    set_input(37);
    measure(1'b1, 0, 10, c, o);
    check("R4 ten periods of 37", c, 370);
    check("R4 no ovf", o, 0);
  endtask

  task automatic t_overflow();
    int c, o;
    set_input(2);
    measure(1'b0, 4, 0, c, o);
    check("R3 freq saturate count", c, 4095);
    check("R3 freq ovf flag", o, 1);
    set_input(300);
    measure(1'b1, 0, 20, c, o);
    check("R3 period saturate count", c, 4095);
    check("R3 period ovf flag", o, 1);
    set_input(10);
    measure(1'b0, 2, 0, c, o);
    check("R8 count after overflow run", c, 10);
    check("R8 ovf cleared", o, 0);
  endtask

  task automatic t_hold_and_ignore();
    int c, o;
    set_input(40);
    kick(1'b1, 0, 4);
    repeat (20) @(negedge clk);
    // second start and new settings while running
    mode = 1'b0; gate_exp = 3'd0; n_avg = AVG_W'(1); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_result(c, o);
    check("R7 R9 result of first settings", c, 160);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R6 valid held", res_valid, 1);
      check("R6 count held", res_count, c);
    end
    accept();
    check("R6 consumed", res_valid, 0);
    repeat (5) @(negedge clk);
    check("R7 no stray measurement", busy, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_freq_exact();
    t_freq_quant();
    t_period();
    t_overflow();
    t_hold_and_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule